// File: doc/BRIEF.md
# Security-Aware System Register Bank

This block holds a handful of processor control registers behind a single request port. A request gives the processor mode (user or privileged), the security state of the requester, a register index, the direction (read or write) and the write data. One cycle later the block answers with a response strobe, read data and an undefined flag. The core turns the undefined flag into an undefined-instruction exception. This block does not handle that exception.

The access check covers several conditions:
- A per-register disable vector can switch off any register.
- One register can be reached only from the Secure state.
- User mode can reach only the thread-identifier register.
- An external write-lock input turns writes to protected registers into undefined accesses.
- The access-gate register sets the Non-secure view of two registers field by field. Each gate bit covers one field. When the bit is 0, that field reads as zero and ignores writes for any Non-secure access.

Three registers keep separate Secure and Non-secure copies. The requester's security state picks the copy. Reset loads only the Secure copies and the unbanked registers. The Non-secure copies hold whatever value they had until software writes them.

Top module: `sreg_ctrl`

## Requirements
- R1: After reset, Secure privileged reads return the parameter reset values: control (index 0), coprocessor access (1), secure configuration (2), translation control (3), Secure vector base (4), access gate (5) and thread identifier (6).
- R2: Indices 0, 3 and 4 are banked. A Secure access reads and writes the Secure copy and a Non-secure access uses the Non-secure copy. A write to one copy leaves the other copy unchanged.
- R3: When bit k of `reg_off` is 1, any read or write to index k is undefined.
- R4: Any Non-secure access to index 2 is undefined.
- R5: For a Non-secure privileged access, field f (FW bits) of index 1 is gated by access-gate bit f, and field f of index 6 is gated by bit NFLD+f. A gate bit of 0 makes its field read as zero and ignore writes. Secure accesses are never gated.
- R6: Index 6 is reachable from user mode, and the R5 gating of its fields also applies to Non-secure user accesses.
- R7: A write to an index whose bit in `LOCK_MASK` is set (default indices 0, 2, 3, 4, 5) while `wr_lock` is 1 is undefined, and the register keeps its value.
- R8: Index 5 accepts reads from both states. Any Non-secure write to index 5 is undefined.
- R9: A user-mode access to any index other than 6 is undefined, in either security state.
- R10: `rsp_vld` follows `req_vld` by exactly one cycle. A write takes effect in that same cycle only if the access is not undefined. `rsp_rdata` is zero for writes and for undefined accesses.
- R11: Index 7 is unimplemented, and any access to it is undefined.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 1 | Request strobe, one cycle per access |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_priv | input | 1 | 1 = privileged mode, 0 = user mode |
| req_ns | input | 1 | 1 = Non-secure requester |
| req_idx | input | 3 | Register index |
| req_wdata | input | DW | Write data |
| reg_off | input | 8 | Per-index access disable |
| wr_lock | input | 1 | Write lock for the indices in LOCK_MASK |
| rsp_vld | output | 1 | Response strobe |
| rsp_undef | output | 1 | Access was undefined |
| rsp_rdata | output | DW | Read data |

## Verification
The bench sweeps every combination of index, mode, security state and direction, with the lock on and off, with the target index disabled and enabled, and under four access-gate patterns. The cases it targets include the following:
- If gating were applied to the wrong field half, a gated field would read back nonzero.
- If banking were missing, a Secure read would return data that was written by a Non-secure access.
- If the lock were checked after the write took effect, later reads would show the locked register changed.
- If the user-mode or secure-only checks were wrong, the bench would see an undefined flag that is missing or spurious, and register contents that diverge from its model.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

   localparam int NREG = 8;
   localparam int IDXW = 3;

   typedef enum logic [IDXW-1:0] {
      IDX_CTRL   = 3'd0,
      IDX_CPACC  = 3'd1,
      IDX_SECCFG = 3'd2,
      IDX_XLAT   = 3'd3,
      IDX_VEC    = 3'd4,
      IDX_GATE   = 3'd5,
      IDX_TID    = 3'd6,
      IDX_NONE   = 3'd7
   } sreg_idx_e;

   typedef struct packed {
      logic impl;      // register exists
      logic banked;    // separate Secure / Non-secure copies
      logic user_ok;   // reachable from user mode
      logic sec_only;  // no field ever reachable from Non-secure
      logic gated;     // fields gated by the access-gate register
      logic gate_hi;   // uses the upper half of the gate bits
   } sreg_attr_t;

   function automatic sreg_attr_t sreg_attr(input logic [IDXW-1:0] idx);
      sreg_attr_t a;
      a = '0;
      case (idx)
         IDX_CTRL:   begin a.impl = 1'b1; a.banked = 1'b1; end
         IDX_CPACC:  begin a.impl = 1'b1; a.gated  = 1'b1; end
         IDX_SECCFG: begin a.impl = 1'b1; a.sec_only = 1'b1; end
         IDX_XLAT:   begin a.impl = 1'b1; a.banked = 1'b1; end
         IDX_VEC:    begin a.impl = 1'b1; a.banked = 1'b1; end
         IDX_GATE:   begin a.impl = 1'b1; end
         IDX_TID:    begin a.impl = 1'b1; a.user_ok = 1'b1;
                           a.gated = 1'b1; a.gate_hi = 1'b1; end
         default:    a = '0;
      endcase
      return a;
   endfunction

endpackage

// File: rtl/sreg_check.sv
module sreg_check
   import sreg_pkg::*;
#(
   parameter logic [NREG-1:0] LOCK_MASK = 8'b0011_1101
) (
   input  logic            wr,
   input  logic            priv,
   input  logic            ns,
   input  logic [IDXW-1:0] idx,
   input  logic [NREG-1:0] reg_off,
   input  logic            wr_lock,
   output logic            undef
);

   sreg_attr_t attr;
   logic no_reg, off_hit, user_bad, sec_bad, gate_wr_bad, lock_bad;

   always_comb begin
      attr        = sreg_attr(idx);
      no_reg      = !attr.impl;
      off_hit     = reg_off[idx];
      user_bad    = !priv && !attr.user_ok;
      sec_bad     = ns && attr.sec_only;
      gate_wr_bad = ns && wr && (idx == IDX_GATE);
      lock_bad    = wr && wr_lock && LOCK_MASK[idx];
      undef       = no_reg | off_hit | user_bad | sec_bad | gate_wr_bad | lock_bad;
   end

endmodule

// File: rtl/sreg_fmask.sv
module sreg_fmask
   import sreg_pkg::*;
#(
   parameter int DW   = 32,
   parameter int NFLD = 4
) (
   input  logic            ns,
   input  logic [IDXW-1:0] idx,
   input  logic [2*NFLD-1:0] gate,
   output logic [DW-1:0]   mask
);

   localparam int FW = DW / NFLD;

   sreg_attr_t attr;
   always_comb attr = sreg_attr(idx);

   for (genvar f = 0; f < NFLD; f++) begin : g_fld
      logic open;
      always_comb open = !ns || !attr.gated ||
                         (attr.gate_hi ? gate[NFLD+f] : gate[f]);
      assign mask[f*FW +: FW] = {FW{open}};
   end

   if (FW * NFLD < DW) begin : g_tail
      assign mask[DW-1:FW*NFLD] = '1;
   end

endmodule

// File: rtl/sreg_bank.sv
module sreg_bank
   import sreg_pkg::*;
#(
   parameter int            DW         = 32,
   parameter int            NFLD       = 4,
   parameter logic [DW-1:0] RST_CTRL   = 32'h0000_0C78,
   parameter logic [DW-1:0] RST_CPACC  = '0,
   parameter logic [DW-1:0] RST_SECCFG = '0,
   parameter logic [DW-1:0] RST_XLAT   = '0,
   parameter logic [DW-1:0] RST_VEC    = '0,
   parameter logic [DW-1:0] RST_GATE   = '0,
   parameter logic [DW-1:0] RST_TID    = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic              ns,
   input  logic [IDXW-1:0]   idx,
   input  logic [DW-1:0]     wdata,
   input  logic [DW-1:0]     wmask,
   output logic [DW-1:0]     rdata,
   output logic [DW-1:0]     gate_q
);

   logic [DW-1:0] view [NREG];

   for (genvar r = 0; r < NREG-1; r++) begin : g_reg
      localparam sreg_attr_t A = sreg_attr(IDXW'(r));
      localparam logic [DW-1:0] RV =
         (r == 0) ? RST_CTRL   :
         (r == 1) ? RST_CPACC  :
         (r == 2) ? RST_SECCFG :
         (r == 3) ? RST_XLAT   :
         (r == 4) ? RST_VEC    :
         (r == 5) ? RST_GATE   : RST_TID;

      logic          hit;
      logic [DW-1:0] s_q;

      assign hit = we && (idx == IDXW'(r));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            s_q <= RV;
         else if (hit && (!A.banked || !ns))
            s_q <= (s_q & ~wmask) | (wdata & wmask);
      end

      if (A.banked) begin : g_ns
         logic [DW-1:0] n_q;
         always_ff @(posedge clk) begin
            if (hit && ns)
               n_q <= (n_q & ~wmask) | (wdata & wmask);
         end
         assign view[r] = ns ? n_q : s_q;
      end else begin : g_flat
         assign view[r] = s_q;
      end
   end

   assign view[NREG-1] = '0;
   assign rdata  = view[idx];
   assign gate_q = view[IDX_GATE];

endmodule

// File: rtl/sreg_ctrl.sv
module sreg_ctrl
   import sreg_pkg::*;
#(
   parameter int              DW         = 32,
   parameter int              NFLD       = 4,
   parameter logic [NREG-1:0] LOCK_MASK  = 8'b0011_1101,
   parameter logic [DW-1:0]   RST_CTRL   = 32'h0000_0C78,
   parameter logic [DW-1:0]   RST_CPACC  = '0,
   parameter logic [DW-1:0]   RST_SECCFG = '0,
   parameter logic [DW-1:0]   RST_XLAT   = '0,
   parameter logic [DW-1:0]   RST_VEC    = '0,
   parameter logic [DW-1:0]   RST_GATE   = '0,
   parameter logic [DW-1:0]   RST_TID    = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_vld,
   input  logic              req_wr,
   input  logic              req_priv,
   input  logic              req_ns,
   input  logic [IDXW-1:0]   req_idx,
   input  logic [DW-1:0]     req_wdata,
   input  logic [NREG-1:0]   reg_off,
   input  logic              wr_lock,
   output logic              rsp_vld,
   output logic              rsp_undef,
   output logic [DW-1:0]     rsp_rdata
);

   localparam int GATEW = 2 * NFLD;

   if (NFLD < 1 || DW % NFLD != 0) begin : g_bad_fld
      $error("sreg_ctrl: DW must be a multiple of NFLD");
   end
   if (GATEW > DW) begin : g_bad_gate
      $error("sreg_ctrl: gate register too narrow for 2*NFLD bits");
   end

   logic          undef;
   logic [DW-1:0] fmask;
   logic [DW-1:0] raw_rd;
   logic [DW-1:0] gate_q;
   logic          we;

   sreg_check #(.LOCK_MASK(LOCK_MASK)) u_check (
      .wr      (req_wr),
      .priv    (req_priv),
      .ns      (req_ns),
      .idx     (req_idx),
      .reg_off (reg_off),
      .wr_lock (wr_lock),
      .undef   (undef)
   );

   sreg_fmask #(.DW(DW), .NFLD(NFLD)) u_fmask (
      .ns   (req_ns),
      .idx  (req_idx),
      .gate (gate_q[GATEW-1:0]),
      .mask (fmask)
   );

   assign we = req_vld && req_wr && !undef;

   sreg_bank #(
      .DW(DW), .NFLD(NFLD),
      .RST_CTRL(RST_CTRL), .RST_CPACC(RST_CPACC), .RST_SECCFG(RST_SECCFG),
      .RST_XLAT(RST_XLAT), .RST_VEC(RST_VEC), .RST_GATE(RST_GATE),
      .RST_TID(RST_TID)
   ) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (we),
      .ns     (req_ns),
      .idx    (req_idx),
      .wdata  (req_wdata),
      .wmask  (fmask),
      .rdata  (raw_rd),
      .gate_q (gate_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_vld   <= 1'b0;
         rsp_undef <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_vld   <= req_vld;
         rsp_undef <= req_vld && undef;
         rsp_rdata <= (req_vld && !undef && !req_wr) ? (raw_rd & fmask) : '0;
      end
   end

endmodule

// File: rtl/sreg_ctrl_chk.sv
module sreg_ctrl_chk
   import sreg_pkg::*;
#(
   parameter int              DW        = 32,
   parameter logic [NREG-1:0] LOCK_MASK = 8'b0011_1101
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_vld,
   input logic              req_wr,
   input logic              req_priv,
   input logic              req_ns,
   input logic [IDXW-1:0]   req_idx,
   input logic [NREG-1:0]   reg_off,
   input logic              wr_lock,
   input logic              rsp_vld,
   input logic              rsp_undef,
   input logic [DW-1:0]     rsp_rdata,
   input logic [DW-1:0]     gate_q
);

   a_r10_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
      req_vld |=> rsp_vld);
   a_r10_rsp_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !req_vld |=> !rsp_vld);
   a_r10_undef_zero: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_undef |-> (rsp_rdata == '0));
   a_r3_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld && reg_off[req_idx]) |=> rsp_undef);
   a_r4_secure_only: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld && req_ns && req_idx == IDX_SECCFG) |=> rsp_undef);
   a_r7_lock: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld && req_wr && wr_lock && LOCK_MASK[req_idx]) |=> rsp_undef);
   a_r8_gate_ns_write: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld && req_wr && req_ns && req_idx == IDX_GATE) |=> rsp_undef);
   a_r8_gate_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld && (req_ns || wr_lock || !req_priv)) |=> $stable(gate_q));
   a_r9_user: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld && !req_priv && req_idx != IDX_TID) |=> rsp_undef);
   a_r11_none: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld && req_idx == IDX_NONE) |=> rsp_undef);

endmodule

bind sreg_ctrl sreg_ctrl_chk #(.DW(DW), .LOCK_MASK(LOCK_MASK)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_wr(req_wr),
   .req_priv(req_priv), .req_ns(req_ns), .req_idx(req_idx),
   .reg_off(reg_off), .wr_lock(wr_lock), .rsp_vld(rsp_vld),
   .rsp_undef(rsp_undef), .rsp_rdata(rsp_rdata), .gate_q(gate_q)
);

// File: tb/tb_sreg_ctrl.sv
module tb_sreg_ctrl;

   localparam int DW = 32;
   localparam logic [7:0]  LOCKM = 8'b0011_1101;
   localparam logic [31:0] RCTRL = 32'h0000_0C78;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_vld = 1'b0, req_wr = 1'b0, req_priv = 1'b0, req_ns = 1'b0;
   logic [2:0]  req_idx = '0;
   logic [31:0] req_wdata = '0;
   logic [7:0]  reg_off = '0;
   logic        wr_lock = 1'b0;
   logic        rsp_vld, rsp_undef;
   logic [31:0] rsp_rdata;

   int checks = 0;
   int errors = 0;
   logic [31:0] ms [8];
   logic [31:0] mn [8];

   always #5 clk = ~clk;

   sreg_ctrl dut (
      .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_wr(req_wr),
      .req_priv(req_priv), .req_ns(req_ns), .req_idx(req_idx),
      .req_wdata(req_wdata), .reg_off(reg_off), .wr_lock(wr_lock),
      .rsp_vld(rsp_vld), .rsp_undef(rsp_undef), .rsp_rdata(rsp_rdata)
   );

   function automatic logic banked(input int i);
      return (i == 0) || (i == 3) || (i == 4);
   endfunction

   function automatic logic [31:0] gmask(input logic ns, input int i);
      logic [31:0] m = '1;
      for (int f = 0; f < 4; f++) begin
         if (ns && i == 1 && !ms[5][f])   m[f*8 +: 8] = 8'h00;
         if (ns && i == 6 && !ms[5][4+f]) m[f*8 +: 8] = 8'h00;
      end
      return m;
   endfunction

   function automatic logic exp_undef(input logic wr, priv, ns, input int i,
                                      input logic lk, input logic [7:0] off);
      return (i == 7) || off[i] || (!priv && i != 6) || (ns && i == 2) ||
             (ns && wr && i == 5) || (wr && lk && LOCKM[i]);
   endfunction

   function automatic string tag_of(input logic wr, priv, ns, input int i,
                                    input logic lk, input logic [7:0] off);
      if (i == 7)                 return "R11";
      if (off[i])                 return "R3";
      if (!priv && i != 6)        return "R9";
      if (ns && i == 2)           return "R4";
      if (ns && wr && i == 5)     return "R8";
      if (wr && lk && LOCKM[i])   return "R7";
      if (ns && i == 6 && !priv)  return "R6";
      if (ns && (i == 1 || i == 6)) return "R5";
      if (banked(i))              return "R2";
      return "R10";
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // one access: drive at negedge, response sampled at the following negedge
   task automatic acc(input logic wr, priv, ns, input int i, input logic [31:0] wd,
                      input logic lk, input logic [7:0] off, input logic model);
      logic eu;
      logic [31:0] er, m, cur;
      string t;
      eu  = exp_undef(wr, priv, ns, i, lk, off);
      m   = gmask(ns, i);
      cur = (banked(i) && ns) ? mn[i] : ms[i];
      er  = (!eu && !wr) ? (cur & m) : 32'h0;
      t   = tag_of(wr, priv, ns, i, lk, off);
      @(negedge clk);
      req_vld = 1'b1; req_wr = wr; req_priv = priv; req_ns = ns;
      req_idx = 3'(i); req_wdata = wd; wr_lock = lk; reg_off = off;
      @(negedge clk);
      req_vld = 1'b0; wr_lock = 1'b0; reg_off = '0;
      if (model) begin
         chk(t, {31'b0, rsp_vld}, 32'h1);
         chk(t, {31'b0, rsp_undef}, {31'b0, eu});
         chk(t, rsp_rdata, er);
      end
      if (!eu && wr) begin
         if (banked(i) && ns) mn[i] = (mn[i] & ~m) | (wd & m);
         else                 ms[i] = (ms[i] & ~m) | (wd & m);
      end
      @(negedge clk);
      if (model) chk("R10", {31'b0, rsp_vld}, 32'h0);
   endtask

   initial begin
      ms[0] = RCTRL;
      for (int k = 1; k < 8; k++) ms[k] = '0;
      for (int k = 0; k < 8; k++) mn[k] = '0;
      repeat (3) @(negedge clk);
      chk("R1", {31'b0, rsp_vld}, 32'h0);
      rst_n = 1'b1;
      // R1: reset values through Secure privileged reads
      for (int i = 0; i < 7; i++) acc(1'b0, 1'b1, 1'b0, i, '0, 1'b0, '0, 1'b1);
      // R2: give the Non-secure copies known contents
      for (int i = 0; i < 5; i++)
         if (banked(i)) acc(1'b1, 1'b1, 1'b1, i, 32'hA000_0000 + 32'(i), 1'b0, '0, 1'b1);
      for (int i = 0; i < 5; i++)
         if (banked(i)) acc(1'b0, 1'b1, 1'b0, i, '0, 1'b0, '0, 1'b1);
      // near-exhaustive sweep
      for (int gp = 0; gp < 4; gp++) begin
         logic [31:0] gv;
         gv = (gp == 0) ? 32'h00 : (gp == 1) ? 32'hA5 : (gp == 2) ? 32'hFF : 32'h5A;
         acc(1'b1, 1'b1, 1'b0, 5, gv, 1'b0, '0, 1'b1);
         for (int lk = 0; lk < 2; lk++)
            for (int om = 0; om < 2; om++)
               for (int ns = 0; ns < 2; ns++)
                  for (int pv = 0; pv < 2; pv++)
                     for (int i = 0; i < 8; i++)
                        for (int wr = 1; wr >= 0; wr--) begin
                           logic [31:0] wd;
                           logic [7:0] off;
                           wd  = 32'h9E37_79B9 * 32'(gp*256 + lk*128 + om*64 + ns*32 + pv*16 + i*2 + wr + 1);
                           off = (om == 1) ? (8'h01 << i) : 8'h00;
                           if (i == 5 && wr == 1 && ns == 0) wd = gv ^ 32'h0000_0F00;
                           acc(wr[0], pv[0], ns[0], i, wd, lk[0], off, 1'b1);
                        end
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule